// File: doc/BRIEF.md
# Four-Wide In-Order Issue Checker

This block sits between instruction fetch and the execution lanes of a four-lane core that runs scalar, vector and matrix instructions on one shared set of lanes. Each cycle it looks at a group of four 32-bit instruction words fetched together, which is one 16-byte fetch step. It decides what goes to the lanes. A run of scalar instructions is checked for register conflicts within the group, and the longest conflict-free leading run is sent out together, one instruction per lane. A vector or matrix instruction is never mixed with scalar work. When it reaches the head of the group, it goes out alone and is spread over one to four lanes, with no conflict check, because its element operations are independent by definition.

Slots that could not go out in a cycle are kept inside the block and offered again, starting at lane 0, on the following cycles. While leftovers remain, the block raises `hold`. Fetch must keep its next group waiting until `hold` falls. Every lane output is registered, so an issue decision shows on the ports one clock after the group is sampled.

Top module: `issue_checker4`

## Requirements
- R1: Instruction word fields are: bit 31 marks a vector/matrix instruction, bit 30 a load/store, bits 29:24 the operation, bits 23:20 the destination, bits 19:16 and 15:12 the two sources, and bit 11 that the destination is written. Bits 10:0 are forwarded unchanged on every lane that carries the instruction, and for a vector/matrix instruction bits 9:8 hold its lane count minus one. Slot i of the group occupies bits 32i+31:32i.
- R2: A group of four mutually independent scalar instructions is issued in a single cycle with lane i carrying slot i. In every cycle the issued lanes form a contiguous run starting at lane 0.
- R3: A scalar slot whose source (bits 19:16 or 15:12) equals the destination of an earlier slot in the same group that has its write bit set ends the issue run at that slot. An earlier slot with the write bit clear creates no such dependency.
- R4: A scalar slot that writes the same destination as an earlier writing slot in the group ends the issue run at that slot.
- R5: A second load/store in the run ends the issue run at that slot, so at most one issued lane carries a load/store.
- R6: A scalar run stops in front of the first vector/matrix slot, and that slot is presented on a later cycle.
- R7: A vector/matrix instruction at the head is issued on its own on lanes 0 up to its lane count minus one, every lane carrying the same fields, with `iss_vm` high. No dependency check is applied.
- R8: Slots left over after an issue are held with `hold` high and presented again, in order and starting at lane 0, on following cycles. While `hold` is high the group inputs are ignored.
- R9: Reset clears all lane valids, `iss_vm` and `hold`, and discards any held slots.
- R10: An issue decision appears on the outputs one clock after the group is sampled, and a cycle with neither a valid group nor held slots issues nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| grp_valid | input | 1 | A fetched group is present |
| grp_insn | input | 128 | Four instruction words, slot 0 in the low bits |
| hold | output | 1 | Leftover slots pending; fetch must wait |
| iss_valid | output | 4 | Per-lane issue valid |
| iss_vm | output | 1 | The issued lanes belong to one vector/matrix instruction |
| iss_mem | output | 4 | Per-lane load/store flag |
| iss_wr | output | 4 | Per-lane destination write flag |
| iss_op | output | 24 | Per-lane operation code, 6 bits each |
| iss_rd | output | 16 | Per-lane destination register, 4 bits each |
| iss_rs | output | 16 | Per-lane first source register, 4 bits each |
| iss_rt | output | 16 | Per-lane second source register, 4 bits each |
| iss_ext | output | 44 | Per-lane extension bits, 11 bits each |

## Verification
Scalar grouping and vector/matrix expansion meet in the same cycle whenever a held remainder starts with a vector/matrix slot. Groups are therefore built with scalar work ahead of a vector/matrix slot, and with a vector/matrix head followed by scalars. The bench then checks that each cycle shows either a pure scalar run or one expanded instruction, never both. Each group's expected per-cycle lane masks and vector flags are tabulated, and every issued lane's fields are compared with the slot that should occupy it. A different junk group is kept on the inputs during the hold cycles to confirm that it never leaks out.

// File: rtl/issue_pkg.sv
package issue_pkg;
  localparam int INSN_W  = 32;
  localparam int OP_W    = 6;
  localparam int REG_W   = 4;
  localparam int EXT_W   = 11;
  localparam int LN_W    = 2;

  localparam int VM_BIT  = 31;
  localparam int MEM_BIT = 30;
  localparam int OP_LSB  = 24;
  localparam int RD_LSB  = 20;
  localparam int RS_LSB  = 16;
  localparam int RT_LSB  = 12;
  localparam int WR_BIT  = 11;
  localparam int LN_LSB  = 8;

  // Fields the dependency scan needs from one slot.
  typedef struct packed {
    logic             vm;
    logic             mem;
    logic             wr;
    logic [REG_W-1:0] rd;
    logic [REG_W-1:0] rs;
    logic [REG_W-1:0] rt;
  } hz_t;
endpackage

// File: rtl/issue_prefix.sv
// Length of the conflict-free scalar run at the head of the current group.
module issue_prefix
  import issue_pkg::*;
#(
  parameter  int LANES = 4,
  localparam int CW    = $clog2(LANES + 1)
) (
  input  hz_t           slot [LANES],
  input  logic [CW-1:0] cnt,
  output logic [CW-1:0] take
);
  logic done;
  logic mem_seen;
  logic hz;

  always_comb begin
    take     = '0;
    done     = 1'b0;
    mem_seen = 1'b0;
    hz       = 1'b0;
    for (int j = 0; j < LANES; j++) begin
      if (!done) begin
        hz = 1'b0;
        for (int i = 0; i < j; i++) begin
          if (slot[i].wr &&
              ((slot[i].rd == slot[j].rs) ||
               (slot[i].rd == slot[j].rt) ||
               (slot[j].wr && (slot[i].rd == slot[j].rd))))
            hz = 1'b1;
        end
        if ((CW'(j) >= cnt) || slot[j].vm || hz || (slot[j].mem && mem_seen)) begin
          done = 1'b1;
        end else begin
          take     = CW'(j + 1);
          mem_seen = mem_seen | slot[j].mem;
        end
      end
    end
  end
endmodule

// File: rtl/issue_vm_expand.sv
// Lane mask for a vector/matrix instruction from its lane-count field.
module issue_vm_expand
  import issue_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic [LN_W-1:0]  lanes_m1,
  output logic [LANES-1:0] mask
);
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign mask[i] = (i <= int'(lanes_m1));
  end
endmodule

// File: rtl/issue_hold_buf.sv
// Storage for slots that did not issue, already shifted down to slot 0.
module issue_hold_buf
  import issue_pkg::*;
#(
  parameter  int LANES = 4,
  localparam int CW    = $clog2(LANES + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [INSN_W-1:0] nxt_word [LANES],
  input  logic [CW-1:0]     nxt_cnt,
  output logic [INSN_W-1:0] buf_word [LANES],
  output logic [CW-1:0]     buf_cnt
);
  always_ff @(posedge clk) begin
    if (rst) buf_cnt <= '0;
    else     buf_cnt <= nxt_cnt;
  end

  for (genvar i = 0; i < LANES; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (CW'(i) < nxt_cnt) buf_word[i] <= nxt_word[i];
    end
  end
endmodule

// File: rtl/issue_checker4.sv
module issue_checker4
  import issue_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    grp_valid,
  input  logic [LANES*INSN_W-1:0] grp_insn,
  output logic                    hold,
  output logic [LANES-1:0]        iss_valid,
  output logic                    iss_vm,
  output logic [LANES-1:0]        iss_mem,
  output logic [LANES-1:0]        iss_wr,
  output logic [LANES*OP_W-1:0]   iss_op,
  output logic [LANES*REG_W-1:0]  iss_rd,
  output logic [LANES*REG_W-1:0]  iss_rs,
  output logic [LANES*REG_W-1:0]  iss_rt,
  output logic [LANES*EXT_W-1:0]  iss_ext
);
  localparam int CW = $clog2(LANES + 1);

  logic [INSN_W-1:0] buf_word  [LANES];
  logic [CW-1:0]     buf_cnt;
  logic [INSN_W-1:0] cur_word  [LANES];
  logic [CW-1:0]     cur_cnt;
  hz_t               cur_hz    [LANES];
  logic [INSN_W-1:0] lane_word [LANES];
  logic [INSN_W-1:0] nxt_word  [LANES];
  logic [CW-1:0]     take;
  logic [CW-1:0]     consumed;
  logic [CW-1:0]     left;
  logic [LANES-1:0]  vm_mask;
  logic [LANES-1:0]  lane_go;
  logic              head_vm;

  assign hold = (buf_cnt != '0);

  // Held slots take precedence over a new group.
  for (genvar i = 0; i < LANES; i++) begin : g_cur
    assign cur_word[i] = hold ? buf_word[i] : grp_insn[i*INSN_W +: INSN_W];
    assign cur_hz[i]   = '{vm:  cur_word[i][VM_BIT],
                           mem: cur_word[i][MEM_BIT],
                           wr:  cur_word[i][WR_BIT],
                           rd:  cur_word[i][RD_LSB +: REG_W],
                           rs:  cur_word[i][RS_LSB +: REG_W],
                           rt:  cur_word[i][RT_LSB +: REG_W]};
  end

  assign cur_cnt = hold ? buf_cnt : (grp_valid ? CW'(LANES) : '0);

  issue_prefix #(.LANES(LANES)) u_prefix (
    .slot (cur_hz),
    .cnt  (cur_cnt),
    .take (take)
  );

  issue_vm_expand #(.LANES(LANES)) u_vmx (
    .lanes_m1 (cur_word[0][LN_LSB +: LN_W]),
    .mask     (vm_mask)
  );

  assign head_vm  = (cur_cnt != '0) && cur_word[0][VM_BIT];
  assign consumed = head_vm ? CW'(1) : take;
  assign left     = cur_cnt - consumed;

  always_comb begin
    for (int i = 0; i < LANES; i++) begin
      lane_go[i]   = head_vm ? vm_mask[i] : (CW'(i) < take);
      lane_word[i] = head_vm ? cur_word[0] : cur_word[i];
    end
  end

  // Shift the remainder so the oldest unissued slot lands in slot 0.
  always_comb begin
    for (int i = 0; i < LANES; i++) begin
      nxt_word[i] = '0;
      if (i + int'(consumed) < LANES) nxt_word[i] = cur_word[i + int'(consumed)];
    end
  end

  issue_hold_buf #(.LANES(LANES)) u_buf (
    .clk      (clk),
    .rst      (rst),
    .nxt_word (nxt_word),
    .nxt_cnt  (left),
    .buf_word (buf_word),
    .buf_cnt  (buf_cnt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      iss_valid <= '0;
      iss_vm    <= 1'b0;
    end else begin
      iss_valid <= lane_go;
      iss_vm    <= head_vm;
    end
  end

  for (genvar i = 0; i < LANES; i++) begin : g_out
    always_ff @(posedge clk) begin
      iss_mem[i]                   <= lane_word[i][MEM_BIT];
      iss_wr[i]                    <= lane_word[i][WR_BIT];
      iss_op[i*OP_W +: OP_W]       <= lane_word[i][OP_LSB +: OP_W];
      iss_rd[i*REG_W +: REG_W]     <= lane_word[i][RD_LSB +: REG_W];
      iss_rs[i*REG_W +: REG_W]     <= lane_word[i][RS_LSB +: REG_W];
      iss_rt[i*REG_W +: REG_W]     <= lane_word[i][RT_LSB +: REG_W];
      iss_ext[i*EXT_W +: EXT_W]    <= lane_word[i][EXT_W-1:0];
    end
  end
endmodule

// File: rtl/issue_checker4_sva.sv
module issue_checker4_sva
  import issue_pkg::*;
#(
  parameter int LANES = 4
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   hold,
  input logic [LANES-1:0]       iss_valid,
  input logic                   iss_vm,
  input logic [LANES-1:0]       iss_mem,
  input logic [LANES-1:0]       iss_wr,
  input logic [LANES*OP_W-1:0]  iss_op,
  input logic [LANES*REG_W-1:0] iss_rd,
  input logic [LANES*REG_W-1:0] iss_rs,
  input logic [LANES*REG_W-1:0] iss_rt
);
  logic raw_seen;
  logic waw_seen;
  logic vm_same;

  always_comb begin
    raw_seen = 1'b0;
    waw_seen = 1'b0;
    vm_same  = 1'b1;
    for (int j = 0; j < LANES; j++) begin
      for (int i = 0; i < j; i++) begin
        if (iss_valid[i] && iss_valid[j] && iss_wr[i]) begin
          if ((iss_rd[i*REG_W +: REG_W] == iss_rs[j*REG_W +: REG_W]) ||
              (iss_rd[i*REG_W +: REG_W] == iss_rt[j*REG_W +: REG_W]))
            raw_seen = 1'b1;
          if (iss_wr[j] && (iss_rd[i*REG_W +: REG_W] == iss_rd[j*REG_W +: REG_W]))
            waw_seen = 1'b1;
        end
      end
      if (iss_valid[j] &&
          ((iss_op[j*OP_W +: OP_W] != iss_op[OP_W-1:0]) ||
           (iss_rd[j*REG_W +: REG_W] != iss_rd[REG_W-1:0])))
        vm_same = 1'b0;
    end
  end

  // R2: issued lanes are a contiguous run from lane 0
  p_lane_run_r2: assert property (@(posedge clk) disable iff (rst)
    (iss_valid & (iss_valid + 1'b1)) == '0);

  p_no_raw_r3: assert property (@(posedge clk) disable iff (rst)
    !iss_vm |-> !raw_seen);

  p_no_waw_r4: assert property (@(posedge clk) disable iff (rst)
    !iss_vm |-> !waw_seen);

  p_one_mem_r5: assert property (@(posedge clk) disable iff (rst)
    $countones(iss_valid & iss_mem) <= 1);

  p_vm_uniform_r7: assert property (@(posedge clk) disable iff (rst)
    iss_vm |-> (iss_valid[0] && vm_same));

  p_hold_drains_r8: assert property (@(posedge clk) disable iff (rst)
    hold |=> (iss_valid != '0));

  p_reset_clear_r9: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (iss_valid == '0 && !iss_vm && !hold));
endmodule

bind issue_checker4 issue_checker4_sva #(.LANES(LANES)) u_sva (
  .clk       (clk),
  .rst       (rst),
  .hold      (hold),
  .iss_valid (iss_valid),
  .iss_vm    (iss_vm),
  .iss_mem   (iss_mem),
  .iss_wr    (iss_wr),
  .iss_op    (iss_op),
  .iss_rd    (iss_rd),
  .iss_rs    (iss_rs),
  .iss_rt    (iss_rt)
);

// File: tb/issue_checker4_test.sv
module issue_checker4_test;
  localparam int CLK_PERIOD = 10;
  localparam int LANES      = 4;
  localparam int NENT       = 9;
  localparam int EW         = 145;

  // R1 encoding: [31] vm, [30] mem, [29:24] op, [23:20] rd, [19:16] rs, [15:12] rt, [11] wr, [9:8] lanes-1
  function automatic logic [31:0] ins(input bit vm, input bit mem, input int op,
                                      input int rd, input int rs, input int rt,
                                      input bit wr, input int nl);
    logic [31:0] w;
    w        = '0;
    w[31]    = vm;
    w[30]    = mem;
    w[29:24] = op[5:0];
    w[23:20] = rd[3:0];
    w[19:16] = rs[3:0];
    w[15:12] = rt[3:0];
    w[11]    = wr;
    w[9:8]   = nl[1:0];
    return w;
  endfunction

  // entry = {cycles, vm flag per cycle, lane mask per cycle (cycle 0 lowest), slot3..slot0}
  function automatic logic [EW-1:0] ent(input logic [31:0] s0, input logic [31:0] s1,
                                        input logic [31:0] s2, input logic [31:0] s3,
                                        input logic [11:0] masks, input logic [2:0] vms,
                                        input logic [1:0] n);
    return {n, vms, masks, s3, s2, s1, s0};
  endfunction

  localparam logic [EW-1:0] TBL [NENT] = '{
    ent(ins(0,0,1,1,2,3,1,0),   ins(0,0,2,4,5,6,1,0),   ins(0,0,3,7,8,9,1,0),   ins(0,0,4,10,11,12,1,0),
        12'b0000_0000_1111, 3'b000, 2'd1),
    ent(ins(0,0,5,1,2,3,1,0),   ins(0,0,6,5,6,7,1,0),   ins(0,0,7,8,1,9,1,0),   ins(0,0,8,10,11,12,1,0),
        12'b0000_0011_0011, 3'b000, 2'd2),
    ent(ins(0,1,9,3,4,5,0,0),   ins(0,0,10,6,3,3,1,0),  ins(0,0,11,7,8,9,1,0),  ins(0,0,12,10,11,12,1,0),
        12'b0000_0000_1111, 3'b000, 2'd1),
    ent(ins(0,0,13,2,3,4,1,0),  ins(0,0,14,2,5,6,1,0),  ins(0,0,15,7,8,9,1,0),  ins(0,0,16,10,11,12,1,0),
        12'b0000_0111_0001, 3'b000, 2'd2),
    ent(ins(0,1,17,1,2,3,1,0),  ins(0,0,18,4,5,6,1,0),  ins(0,1,19,9,10,11,1,0), ins(0,0,20,12,13,14,1,0),
        12'b0000_0011_0011, 3'b000, 2'd2),
    ent(ins(0,0,21,1,2,3,1,0),  ins(0,0,22,4,5,6,1,0),  ins(1,0,23,7,8,9,1,3),  ins(0,0,24,10,11,12,1,0),
        12'b0001_1111_0011, 3'b010, 2'd3),
    ent(ins(1,0,25,1,2,3,1,1),  ins(0,0,26,4,5,6,1,0),  ins(0,0,27,7,8,9,1,0),  ins(0,0,28,10,11,12,1,0),
        12'b0000_0111_0011, 3'b001, 2'd2),
    ent(ins(1,0,29,1,2,3,1,0),  ins(1,0,30,4,5,6,1,2),  ins(0,0,31,7,8,9,1,0),  ins(0,0,32,10,11,12,1,0),
        12'b0011_0111_0001, 3'b011, 2'd3),
    ent(ins(0,0,33,1,2,3,1,0),  ins(0,0,34,4,5,6,1,0),  ins(0,0,35,7,8,9,1,0),  ins(0,0,36,10,11,4,1,0),
        12'b0000_0001_0111, 3'b000, 2'd2)
  };

  string etag [NENT] = '{"R2", "R3", "R3", "R4", "R5", "R6", "R7", "R7", "R3"};

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         grp_valid = 1'b0;
  logic [127:0] grp_insn = '0;
  logic         hold;
  logic [3:0]   iss_valid;
  logic         iss_vm;
  logic [3:0]   iss_mem;
  logic [3:0]   iss_wr;
  logic [23:0]  iss_op;
  logic [15:0]  iss_rd;
  logic [15:0]  iss_rs;
  logic [15:0]  iss_rt;
  logic [43:0]  iss_ext;

  int nchk  = 0;
  int nfail = 0;
  bit done  = 1'b0;

  issue_checker4 #(.LANES(LANES)) uut (
    .clk(clk), .rst(rst), .grp_valid(grp_valid), .grp_insn(grp_insn),
    .hold(hold), .iss_valid(iss_valid), .iss_vm(iss_vm), .iss_mem(iss_mem),
    .iss_wr(iss_wr), .iss_op(iss_op), .iss_rd(iss_rd), .iss_rs(iss_rs),
    .iss_rt(iss_rt), .iss_ext(iss_ext)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  localparam logic [127:0] JUNK = {4{32'h3FFF_F800}};

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R9", "valid in reset", 32'(iss_valid), 0);
    chk("R9", "hold in reset", 32'(hold), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R10", "idle issue", 32'(iss_valid), 0);

    // R10: one clock of latency
    grp_insn = TBL[0][127:0];
    grp_valid = 1'b1;
    #1;
    chk("R10", "before edge", 32'(iss_valid), 0);
    @(negedge clk);
    chk("R10", "after edge", 32'(iss_valid), 32'hF);
    grp_valid = 1'b0;
    @(negedge clk);

    // R1: extension bits forwarded, slot 0 on lane 0
    grp_insn = {ins(0,0,44,13,14,15,1,0), ins(0,0,43,10,11,12,1,0),
                ins(0,0,42,7,8,9,1,0), {2'b00, 6'd40, 4'd1, 4'd2, 4'd3, 1'b1, 11'h5A5}};
    grp_valid = 1'b1;
    @(negedge clk);
    chk("R1", "ext lane0", 32'(iss_ext[10:0]), 32'h5A5);
    chk("R1", "op lane0", 32'(iss_op[5:0]), 40);
    chk("R1", "rs lane3", 32'(iss_rs[15:12]), 14);
    grp_valid = 1'b0;
    @(negedge clk);

    // table of groups, drained cycle by cycle
    for (int e = 0; e < NENT; e++) begin
      logic [EW-1:0] t;
      int pos;
      int n;
      t = TBL[e];
      n = int'(t[144:143]);
      pos = 0;
      grp_insn = t[127:0];
      grp_valid = 1'b1;
      for (int c = 0; c < n; c++) begin
        logic [3:0] em;
        logic       ev;
        @(negedge clk);
        em = t[128 + c*4 +: 4];
        ev = t[140 + c];
        chk(etag[e], $sformatf("entry %0d cyc %0d mask", e, c), 32'(iss_valid), 32'(em));
        chk(etag[e], $sformatf("entry %0d cyc %0d vm", e, c), 32'(iss_vm), 32'(ev));
        chk("R8", $sformatf("entry %0d cyc %0d hold", e, c), 32'(hold), 32'(c < n - 1));
        for (int l = 0; l < LANES; l++) begin
          if (em[l]) begin
            logic [31:0] w;
            int s;
            s = ev ? pos : pos + l;
            w = t[s*32 +: 32];
            chk(etag[e], $sformatf("entry %0d cyc %0d lane %0d op", e, c, l),
                32'(iss_op[l*6 +: 6]), 32'(w[29:24]));
            chk(etag[e], $sformatf("entry %0d cyc %0d lane %0d rd", e, c, l),
                32'(iss_rd[l*4 +: 4]), 32'(w[23:20]));
          end
        end
        pos += ev ? 1 : $countones(em);
        if (c < n - 1) grp_insn = JUNK;
        else           grp_valid = 1'b0;
      end
      @(negedge clk);
      chk("R8", $sformatf("entry %0d junk ignored", e), 32'(iss_valid), 0);
    end

    // R9: reset while slots are held discards them
    grp_insn = TBL[1][127:0];
    grp_valid = 1'b1;
    @(negedge clk);
    chk("R8", "hold raised", 32'(hold), 1);
    grp_valid = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    chk("R9", "hold after reset", 32'(hold), 0);
    chk("R9", "valid after reset", 32'(iss_valid), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R9", "no replay after reset", 32'(iss_valid), 0);

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule